// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block models a small reprogrammable sum-of-products device. It has twelve dedicated logic inputs and ten output cells. Each cell ORs its own group of product terms, and the size of that group differs from cell to cell. The result either drives the output directly or goes through a D register, chosen per cell by a configuration bit. Every product term can use the true or complement form of each input and of each register's output, which is fed back into the array.

Two further product terms are shared by all ten registers. One clears them at the next clock edge and the other clears them at once, with no clock needed. A parallel preload port writes any value into the registers for test, bypassing the array. A power-down input freezes the block: the inputs are held at their last sampled values, and the registers, outputs and configuration stay still.

The configuration store is one circular chain of bits, written and read one bit per handshake. Configuration enters on a valid/ready stream. The block accepts a bit when `cfg_in_valid` and `cfg_in_ready` are both high at a clock edge. It lowers `cfg_in_ready` during power-down and while locked, and the sender must then hold the bit.

Readback leaves on a second valid/ready stream. A bit is consumed when `rb_valid` and `rb_ready` are both high. While `rb_ready` is low, the chain stays put and `rb_bit` does not change.

A security bit, once set, blanks readback and refuses new configuration. Only an erase clears it, and an erase also zeroes every configuration bit.

Top module: `pla_array`

## Requirements
- R1: Reset leaves the registers, the held inputs, every configuration bit and the security bit at zero. With a blank configuration every cell is combinational and every output reads 1; `cfg_in_ready` reads 1 and `rb_bit` reads 0.
- R2: The configuration chain is 5378 bits and is shifted in highest index first.
  - Signals are numbered s: inputs 0 to 11, then register outputs 12 to 21.
  - Term t occupies bits 44t to 44t+43. Bit 44t+2s connects the true form of signal s and bit 44t+2s+1 connects its complement.
  - Terms 0 to 119 belong to the cells in order, in groups of 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. Term 120 is the synchronous clear and term 121 is the asynchronous clear.
  - Bit 5368+i set to 1 makes cell i registered.
- R3: A product term is the AND of its connected literals. A term with no connection is 1. A term that connects both forms of one signal is 0.
- R4: Each cell's sum is the OR of its own terms. A registered cell shows its register, which loads the sum on each clock edge. A combinational cell shows the sum directly.
- R5: When the synchronous-clear term is true at a clock edge, all registers become 0. A clear term with no connection is 0.
- R6: While the asynchronous-clear term is true, all registers read 0 without waiting for a clock edge.
- R7: With `preload_en` high at an edge, the registers load `preload_val`. This takes priority over the synchronous clear and the array.
- R8: `rb_valid` is high when neither power-down, `cfg_in_valid` nor erase is asserted. When unlocked, `rb_bit` is the chain's top bit. Each accepted read rotates the chain by one, so the bits return in the order they were loaded and a full pass restores the chain. With `rb_ready` low, `rb_bit` holds.
- R9: After `sec_set`, `rb_bit` reads 0 and `cfg_in_ready` is 0. Reads do not rotate the chain, and the programmed logic keeps working.
- R10: `erase` zeroes every configuration bit and the security bit at the next edge. It takes priority over configuration shifting.
- R11: While `pwr_down` is high:
  - The array sees the inputs sampled at the last edge before power-down.
  - The registers, the outputs, the chain and the security bit do not change.
  - `cfg_in_ready` and `rb_valid` are 0.
  - `preload_en`, `erase` and `sec_set` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| pins_in | input | 12 | Dedicated logic inputs |
| dout | output | 10 | Cell outputs |
| pwr_down | input | 1 | Freeze inputs, state and outputs |
| preload_en | input | 1 | Load `preload_val` into the registers |
| preload_val | input | 10 | Register preload value |
| cfg_in_valid | input | 1 | Configuration bit offered |
| cfg_in_ready | output | 1 | Configuration bit can be taken |
| cfg_in_bit | input | 1 | Configuration bit |
| rb_valid | output | 1 | Readback bit available |
| rb_ready | input | 1 | Readback consumer ready |
| rb_bit | output | 1 | Readback bit |
| erase | input | 1 | Clear configuration and security bit |
| sec_set | input | 1 | Set the security bit |

## Verification
The assertions are checked on every cycle, and they cover the following:
- The registers are zero whenever the asynchronous-clear term is true, and they are zero one edge after the synchronous clear.
- The outputs stay frozen across consecutive power-down cycles.
- Locking blanks readback and blocks configuration input.
- Readback holds its bit under back-pressure.
- An erase unlocks the block and blanks the chain.

Only the bench's scenarios can show the following, because they need whole sequences:
- The chain contents come back in load order.
- A loaded counter counts and wraps, and the decoder and XOR functions are correct.
- Preload wins over the synchronous clear.
- The counter resumes exactly one step past its held value after power-down.
- Erase and preload are ignored while powered down.

// File: rtl/pla_pkg.sv
package pla_pkg;

  localparam int NUM_IN_DEF  = 12;
  localparam int NUM_MC_DEF  = 10;
  localparam int PT_MIN_DEF  = 8;
  localparam int PT_STEP_DEF = 2;

  // Term count of cell idx: rises by step towards the middle, then falls.
  function automatic int pt_cnt(int nmc, int pmin, int step, int idx);
    int j;
    j = (idx < nmc / 2) ? idx : (nmc - 1 - idx);
    return pmin + step * j;
  endfunction

  // First term index of cell idx.
  function automatic int pt_off(int nmc, int pmin, int step, int idx);
    int s;
    s = 0;
    for (int k = 0; k < idx; k++) s += pt_cnt(nmc, pmin, step, k);
    return s;
  endfunction

  typedef enum logic [1:0] {
    CH_HOLD,
    CH_SHIFT,
    CH_ROTATE,
    CH_CLEAR
  } chain_op_e;

endpackage

// File: rtl/pla_fuse_chain.sv
module pla_fuse_chain
  import pla_pkg::*;
#(
  parameter int N_BITS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              erase,
  input  logic              sec_set,
  input  logic              cfg_in_valid,
  output logic              cfg_in_ready,
  input  logic              cfg_in_bit,
  output logic              rb_valid,
  input  logic              rb_ready,
  output logic              rb_bit,
  output logic [N_BITS-1:0] fuses,
  output logic              locked
);

  logic [N_BITS-1:0] chain_q;
  logic              lock_q;
  chain_op_e         op;

  assign cfg_in_ready = !pwr_down && !lock_q;
  assign rb_valid     = !pwr_down && !cfg_in_valid && !erase;
  assign rb_bit       = lock_q ? 1'b0 : chain_q[N_BITS-1];
  assign fuses        = chain_q;
  assign locked       = lock_q;

  always_comb begin
    op = CH_HOLD;
    if (!pwr_down) begin
      if (erase)                              op = CH_CLEAR;
      else if (cfg_in_valid && cfg_in_ready)  op = CH_SHIFT;
      else if (rb_valid && rb_ready && !lock_q) op = CH_ROTATE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      unique case (op)
        CH_CLEAR:  chain_q <= '0;
        CH_SHIFT:  chain_q <= {chain_q[N_BITS-2:0], cfg_in_bit};
        CH_ROTATE: chain_q <= {chain_q[N_BITS-2:0], chain_q[N_BITS-1]};
        default:   chain_q <= chain_q;
      endcase
      if (!pwr_down) begin
        if (erase)        lock_q <= 1'b0;
        else if (sec_set) lock_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int SIG_W   = 22,
  parameter int N_TERMS = 122,
  parameter int N_GATED = 2,
  localparam int LIT_W  = 2 * SIG_W
) (
  input  logic [SIG_W-1:0]         sig,
  input  logic [N_TERMS*LIT_W-1:0] conn_bits,
  output logic [N_TERMS-1:0]       terms
);

  logic [LIT_W-1:0] lit;

  always_comb begin
    for (int s = 0; s < SIG_W; s++) begin
      lit[2*s]   = sig[s];
      lit[2*s+1] = ~sig[s];
    end
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [LIT_W-1:0] conn;
    assign conn = conn_bits[t*LIT_W +: LIT_W];
    if (t >= N_TERMS - N_GATED) begin : g_gated
      // Clear terms stay inactive until something is connected.
      assign terms[t] = (|conn) & (&(lit | ~conn));
    end else begin : g_plain
      assign terms[t] = &(lit | ~conn);
    end
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int NUM_MC  = 10,
  parameter int PT_MIN  = 8,
  parameter int PT_STEP = 2,
  parameter int N_PT    = 120
) (
  input  logic [N_PT-1:0]   terms,
  output logic [NUM_MC-1:0] sums
);

  for (genvar m = 0; m < NUM_MC; m++) begin : g_sum
    localparam int OFF = pla_pkg::pt_off(NUM_MC, PT_MIN, PT_STEP, m);
    localparam int CNT = pla_pkg::pt_cnt(NUM_MC, PT_MIN, PT_STEP, m);
    assign sums[m] = |terms[OFF +: CNT];
  end

endmodule

// File: rtl/pla_regbank.sv
module pla_regbank #(
  parameter int NUM_MC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              ar_term,
  input  logic              sr_term,
  input  logic              preload_en,
  input  logic [NUM_MC-1:0] preload_val,
  input  logic [NUM_MC-1:0] d,
  output logic [NUM_MC-1:0] q
);

  logic clr_async;
  assign clr_async = !rst_n || ar_term;

  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async) begin
      q <= '0;
    end else if (!hold) begin
      if (preload_en)   q <= preload_val;
      else if (sr_term) q <= '0;
      else              q <= d;
    end
  end

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int NUM_IN  = NUM_IN_DEF,
  parameter int NUM_MC  = NUM_MC_DEF,
  parameter int PT_MIN  = PT_MIN_DEF,
  parameter int PT_STEP = PT_STEP_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] pins_in,
  output logic [NUM_MC-1:0] dout,
  input  logic              pwr_down,
  input  logic              preload_en,
  input  logic [NUM_MC-1:0] preload_val,
  input  logic              cfg_in_valid,
  output logic              cfg_in_ready,
  input  logic              cfg_in_bit,
  output logic              rb_valid,
  input  logic              rb_ready,
  output logic              rb_bit,
  input  logic              erase,
  input  logic              sec_set
);

  localparam int SIG_W     = NUM_IN + NUM_MC;
  localparam int LIT_W     = 2 * SIG_W;
  localparam int N_PT      = pt_off(NUM_MC, PT_MIN, PT_STEP, NUM_MC);
  localparam int N_TERMS   = N_PT + 2;
  localparam int AND_BITS  = N_TERMS * LIT_W;
  localparam int FUSE_BITS = AND_BITS + NUM_MC;

  logic [FUSE_BITS-1:0] fuses;
  logic                 lock_w;
  logic [NUM_IN-1:0]    in_hold;
  logic [NUM_IN-1:0]    in_eff;
  logic [NUM_MC-1:0]    reg_q;
  logic [NUM_MC-1:0]    sums;
  logic [NUM_MC-1:0]    mode;
  logic [N_TERMS-1:0]   terms;
  logic                 sr_term;
  logic                 ar_term;

  // Input hold: sampled every edge outside power-down, selected during it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_hold <= '0;
    else if (!pwr_down) in_hold <= pins_in;
  end
  assign in_eff = pwr_down ? in_hold : pins_in;

  pla_fuse_chain #(.N_BITS(FUSE_BITS)) u_chain (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_down     (pwr_down),
    .erase        (erase),
    .sec_set      (sec_set),
    .cfg_in_valid (cfg_in_valid),
    .cfg_in_ready (cfg_in_ready),
    .cfg_in_bit   (cfg_in_bit),
    .rb_valid     (rb_valid),
    .rb_ready     (rb_ready),
    .rb_bit       (rb_bit),
    .fuses        (fuses),
    .locked       (lock_w)
  );

  pla_and_plane #(.SIG_W(SIG_W), .N_TERMS(N_TERMS), .N_GATED(2)) u_and (
    .sig       ({reg_q, in_eff}),
    .conn_bits (fuses[AND_BITS-1:0]),
    .terms     (terms)
  );

  assign sr_term = terms[N_PT];
  assign ar_term = terms[N_PT+1];

  pla_or_plane #(.NUM_MC(NUM_MC), .PT_MIN(PT_MIN), .PT_STEP(PT_STEP), .N_PT(N_PT)) u_or (
    .terms (terms[N_PT-1:0]),
    .sums  (sums)
  );

  pla_regbank #(.NUM_MC(NUM_MC)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (pwr_down),
    .ar_term     (ar_term),
    .sr_term     (sr_term),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .d           (sums),
    .q           (reg_q)
  );

  assign mode = fuses[AND_BITS +: NUM_MC];
  assign dout = (mode & reg_q) | (~mode & sums);

endmodule

// File: rtl/pla_checker.sv
module pla_checker #(
  parameter int NUM_MC = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_down,
  input logic [NUM_MC-1:0] dout,
  input logic              erase,
  input logic              sec_set,
  input logic              preload_en,
  input logic              cfg_in_ready,
  input logic              rb_valid,
  input logic              rb_ready,
  input logic              rb_bit,
  input logic              locked,
  input logic [NUM_MC-1:0] q,
  input logic              sr_term,
  input logic              ar_term
);

  AST_PD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down && $past(pwr_down) |-> $stable(dout)); // R11

  AST_LOCK_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!rb_bit && !cfg_in_ready)); // R9

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sr_term && !preload_en && !pwr_down |=> (q == '0)); // R5

  AST_ASYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ar_term |-> (q == '0)); // R6

  AST_RB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid && !rb_ready && !sec_set |=> $stable(rb_bit)); // R8

  AST_ERASE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    erase && !pwr_down |=> (!locked && !rb_bit)); // R10

endmodule

bind pla_array pla_checker #(.NUM_MC(NUM_MC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_down     (pwr_down),
  .dout         (dout),
  .erase        (erase),
  .sec_set      (sec_set),
  .preload_en   (preload_en),
  .cfg_in_ready (cfg_in_ready),
  .rb_valid     (rb_valid),
  .rb_ready     (rb_ready),
  .rb_bit       (rb_bit),
  .locked       (lock_w),
  .q            (reg_q),
  .sr_term      (sr_term),
  .ar_term      (ar_term)
);

// File: tb/tb_pla_array.sv
`timescale 1ns/100ps
module tb_pla_array;

  localparam int NIN   = 12;
  localparam int NMC   = 10;
  localparam int SIGW  = NIN + NMC;
  localparam int LITW  = 2 * SIGW;
  localparam int NPT   = 120;
  localparam int NTERM = NPT + 2;
  localparam int ANDB  = NTERM * LITW;
  localparam int NF    = ANDB + NMC;

  int pt_n [NMC] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NIN-1:0] pins = '0;
  logic [NMC-1:0] dout;
  logic           pwr_down = 1'b0;
  logic           preload_en = 1'b0;
  logic [NMC-1:0] preload_val = '0;
  logic           cfg_in_valid = 1'b0;
  logic           cfg_in_ready;
  logic           cfg_in_bit = 1'b0;
  logic           rb_valid;
  logic           rb_ready = 1'b0;
  logic           rb_bit;
  logic           erase = 1'b0;
  logic           sec_set = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit seen_rb;

  bit             cfg    [NF];
  bit             m_fuse [NF];
  bit             m_lock;
  bit [NMC-1:0]   m_q;
  bit [NIN-1:0]   m_hold;

  always #2.5 clk = ~clk;

  pla_array dut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins), .dout(dout), .pwr_down(pwr_down),
    .preload_en(preload_en), .preload_val(preload_val),
    .cfg_in_valid(cfg_in_valid), .cfg_in_ready(cfg_in_ready), .cfg_in_bit(cfg_in_bit),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_bit(rb_bit),
    .erase(erase), .sec_set(sec_set)
  );

  function automatic void chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endfunction

  // ---------------- reference model ----------------
  function automatic int pbase(int mc);
    int s = 0;
    for (int k = 0; k < mc; k++) s += pt_n[k];
    return s;
  endfunction

  function automatic bit sigv(int s);
    bit [NIN-1:0] ie;
    ie = pwr_down ? m_hold : pins;
    return (s < NIN) ? ie[s] : m_q[s-NIN];
  endfunction

  function automatic bit term_val(int t, bit gated);
    bit any = 0;
    bit ok = 1;
    for (int s = 0; s < SIGW; s++) begin
      bit v = sigv(s);
      if (m_fuse[t*LITW + 2*s])   begin any = 1; if (!v) ok = 0; end
      if (m_fuse[t*LITW + 2*s+1]) begin any = 1; if (v)  ok = 0; end
    end
    return gated ? (any && ok) : ok;
  endfunction

  function automatic bit sum_val(int mc);
    bit r = 0;
    int b = pbase(mc);
    for (int c = 0; c < pt_n[mc]; c++) if (term_val(b + c, 0)) r = 1;
    return r;
  endfunction

  function automatic void settle();
    for (int i = 0; i < 3; i++) if (term_val(NTERM-1, 1)) m_q = '0;
  endfunction

  function automatic bit [NMC-1:0] exp_dout();
    bit [NMC-1:0] r;
    for (int i = 0; i < NMC; i++) r[i] = m_fuse[ANDB+i] ? m_q[i] : sum_val(i);
    return r;
  endfunction

  function automatic void model_reset();
    foreach (m_fuse[i]) m_fuse[i] = 0;
    m_lock = 0; m_q = '0; m_hold = '0;
  endfunction

  function automatic void model_clk();
    bit [NMC-1:0] nq;
    bit arp, srp, old_lock, top;
    if (!rst_n) begin model_reset(); return; end
    if (pwr_down) return;
    arp = term_val(NTERM-1, 1);
    srp = term_val(NTERM-2, 1);
    for (int i = 0; i < NMC; i++) nq[i] = sum_val(i);
    if (arp) nq = '0;
    else if (preload_en) nq = preload_val;
    else if (srp) nq = '0;
    old_lock = m_lock;
    if (erase) begin
      foreach (m_fuse[i]) m_fuse[i] = 0;
      m_lock = 0;
    end else begin
      if (cfg_in_valid && !old_lock) begin
        for (int i = NF-1; i > 0; i--) m_fuse[i] = m_fuse[i-1];
        m_fuse[0] = cfg_in_bit;
      end else if (!cfg_in_valid && rb_ready && !old_lock) begin
        top = m_fuse[NF-1];
        for (int i = NF-1; i > 0; i--) m_fuse[i] = m_fuse[i-1];
        m_fuse[0] = top;
      end
      if (sec_set) m_lock = 1;
    end
    m_hold = pins;
    m_q = nq;
    settle();
  endfunction

  // One cycle: inputs already set at the falling edge.
  task automatic tick();
    #1;
    if (rst_n) begin
      settle();
      chk("R4 dout vs model", dout, exp_dout());
      chk("R9 cfg_in_ready vs model", cfg_in_ready, (!pwr_down && !m_lock));
      chk("R8 rb_valid vs model", rb_valid, (!pwr_down && !cfg_in_valid && !erase));
      chk("R8 rb_bit vs model", rb_bit, (m_lock ? 0 : m_fuse[NF-1]));
    end
    seen_rb = rb_bit;
    @(posedge clk);
    model_clk();
    @(negedge clk);
  endtask

  // ---------------- configuration image ----------------
  function automatic void lit(int t, int s, bit neg);
    cfg[t*LITW + 2*s + (neg ? 1 : 0)] = 1;
  endfunction

  function automatic void kill(int t);
    lit(t, 0, 0); lit(t, 0, 1);
  endfunction

  function automatic void build_cfg();
    int b;
    foreach (cfg[i]) cfg[i] = 0;
    // 4-bit counter on cells 0..3, enable pins[0]
    for (int k = 0; k < 4; k++) begin
      b = pbase(k);
      cfg[ANDB+k] = 1;
      lit(b, NIN+k, 0); lit(b, 0, 1);
      for (int j = 0; j < k; j++) begin lit(b+1+j, NIN+k, 0); lit(b+1+j, NIN+j, 1); end
      lit(b+k+1, NIN+k, 1); lit(b+k+1, 0, 0);
      for (int j = 0; j < k; j++) lit(b+k+1, NIN+j, 0);
      for (int c = k+2; c < pt_n[k]; c++) kill(b+c);
    end
    // 2-to-4 decoder of pins[2:1] on cells 4..7
    for (int v = 0; v < 4; v++) begin
      b = pbase(4+v);
      lit(b, 1, (v & 1) == 0);
      lit(b, 2, ((v >> 1) & 1) == 0);
      for (int c = 1; c < pt_n[4+v]; c++) kill(b+c);
    end
    // XOR of pins[3], pins[4] on cell 8
    b = pbase(8);
    lit(b, 3, 0); lit(b, 4, 1);
    lit(b+1, 3, 1); lit(b+1, 4, 0);
    for (int c = 2; c < pt_n[8]; c++) kill(b+c);
    // registered copy of pins[5] on cell 9
    b = pbase(9);
    cfg[ANDB+9] = 1;
    lit(b, 5, 0);
    for (int c = 1; c < pt_n[9]; c++) kill(b+c);
    lit(NPT, 11, 0);    // sync clear on pins[11]
    lit(NPT+1, 10, 0);  // async clear on pins[10]
  endfunction

  // ---------------- stimulus ----------------
  initial begin : main
    int cnt, mism;
    bit [NMC-1:0] held;
    bit hold_rb;
    model_reset();
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk("R1 blank outputs", dout, 10'h3FF);
    chk("R1 cfg_in_ready", cfg_in_ready, 1);
    chk("R1 rb_bit", rb_bit, 0);
    @(negedge clk);
    tick();

    // R2: program
    build_cfg();
    cfg_in_valid = 1'b1;
    for (int i = NF-1; i >= 0; i--) begin
      cfg_in_bit = cfg[i];
      tick();
    end
    cfg_in_valid = 1'b0;
    cfg_in_bit   = 1'b0;

    // R2/R8: full readback returns load order and restores the chain
    mism = 0;
    rb_ready = 1'b1;
    for (int i = 0; i < NF; i++) begin
      tick();
      if (seen_rb != cfg[NF-1-i]) mism++;
    end
    chk("R2 readback mismatches", mism, 0);
    rb_ready = 1'b0;
    hold_rb = rb_bit;
    repeat (3) tick();
    chk("R8 rb_bit held under back-pressure", rb_bit, hold_rb);

    // R5: sync clear
    pins = 12'h800;
    tick();
    chk("R5 sync clear counter", dout[3:0], 0);
    chk("R5 sync clear cell9", dout[9], 0);

    // R4: counter
    cnt = 0;
    pins = 12'h001;
    for (int i = 0; i < 20; i++) begin
      tick();
      cnt = (cnt + 1) % 16;
      chk("R4 counter", dout[3:0], cnt);
    end

    // R4: decoder and XOR
    for (int v = 0; v < 4; v++) begin
      pins = 12'(v << 1);
      tick();
      chk("R4 decoder", dout[7:4], (1 << v));
    end
    pins = 12'h008; tick(); chk("R4 xor 10", dout[8], 1);
    pins = 12'h018; tick(); chk("R4 xor 11", dout[8], 0);

    // R3: killed terms leave cell 9 as a plain register of pins[5]
    pins = 12'h020; tick(); chk("R3 cell9 high", dout[9], 1);
    pins = 12'h000; tick(); chk("R3 cell9 low", dout[9], 0);

    // R7: preload beats sync clear
    preload_en = 1'b1; preload_val = 10'h20A; pins = 12'h800;
    tick();
    preload_en = 1'b0;
    chk("R7 preload counter", dout[3:0], 4'hA);
    chk("R7 preload cell9", dout[9], 1);

    // R6: async clear without a clock edge
    pins = 12'h000;
    preload_en = 1'b1; preload_val = 10'h20F;
    tick();
    preload_en = 1'b0;
    pins = 12'h400;
    #1;
    chk("R6 async clear counter", dout[3:0], 0);
    chk("R6 async clear cell9", dout[9], 0);
    tick();
    pins = 12'h000;
    tick();

    // R11: power-down hold
    pins = 12'h001;
    cnt = 0;
    repeat (3) begin tick(); cnt = (cnt + 1) % 16; end
    held = dout;
    pwr_down = 1'b1;
    pins = 12'hB5E;
    preload_en = 1'b1; preload_val = 10'h000;
    erase = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R11 outputs frozen", dout, held);
      chk("R11 cfg_in_ready low", cfg_in_ready, 0);
      chk("R11 rb_valid low", rb_valid, 0);
      pins = 12'(12'h3A7 + i);
    end
    erase = 1'b0; preload_en = 1'b0;
    pwr_down = 1'b0;
    pins = 12'h001;
    tick();
    cnt = (cnt + 1) % 16;
    chk("R11 counter resumes", dout[3:0], cnt);

    // R9: lock
    sec_set = 1'b1;
    tick();
    sec_set = 1'b0;
    cnt = (cnt + 1) % 16;
    chk("R9 ready low when locked", cfg_in_ready, 0);
    rb_ready = 1'b1;
    mism = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      cnt = (cnt + 1) % 16;
      if (seen_rb != 0) mism++;
    end
    chk("R9 locked readback zeros", mism, 0);
    chk("R9 logic intact when locked", dout[3:0], cnt);
    rb_ready = 1'b0;

    // R10: erase
    pins = 12'h000;
    erase = 1'b1;
    tick();
    erase = 1'b0;
    chk("R10 unlocked", cfg_in_ready, 1);
    chk("R10 blank outputs", dout, 10'h3FF);
    rb_ready = 1'b1;
    mism = 0;
    for (int i = 0; i < 16; i++) begin
      tick();
      if (seen_rb != 0) mism++;
    end
    chk("R10 chain zeroed", mism, 0);
    rb_ready = 1'b0;
    tick();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule